// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block translates the architectural register numbers of a group of up to four instructions into physical register numbers of a larger register file. Every instruction in the group that writes a register receives a physical register that is not in use, and the mapping table is updated so that later readers find the new location. Source operands are looked up in the mapping table. When an earlier instruction in the same group writes the register that a later source reads, the source is steered to the newly assigned physical register instead.

Each writer also reports the physical register its destination was mapped to before the rename. The downstream pipeline returns that old register through a release port when the writer retires, and the register becomes available again on the following cycle. When the pool of available registers cannot cover every writer in the group, the group is held: nothing is assigned and the table does not change.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i below 32, and physical registers 32 to 63 are the only ones available.
- R2: Every writer in an accepted group receives a physical register that was available, and no two writers in one group receive the same register.
- R3: A source that no earlier writer in its group targets reads the mapping table as it stands before the group.
- R4: A source that an earlier writer in its group targets receives the physical register assigned to the nearest such earlier writer.
- R5: When several writers in one group target the same register, the last one's assignment stays in the table, and each later writer's previous-mapping output is the register just assigned to the writer before it.
- R6: Each writer outputs the previous mapping of its destination register.
- R7: A valid group is accepted (grp_ok high) only when the available registers are at least the number of writers in it; otherwise the table and the pool are left unchanged. A group with no writers is always accepted.
- R8: Architectural register 0 is never renamed: a write to it allocates nothing and reports physical register 0 as new and old mapping, and a read of it always yields physical register 0.
- R9: A physical register presented on the release port becomes available from the next cycle.
- R10: Writers take available physical registers in ascending register number, the first writer of the group (lowest slot) taking the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A rename group is presented |
| grp_wen | input | 4 | Per-slot register write enable |
| grp_dst | input | 4x5 | Per-slot destination architectural register |
| grp_src1 | input | 4x5 | Per-slot first source architectural register |
| grp_src2 | input | 4x5 | Per-slot second source architectural register |
| grp_ok | output | 1 | The group is accepted this cycle |
| ren_pdst | output | 4x6 | Newly assigned physical destination per slot |
| ren_psrc1 | output | 4x6 | Physical register of first source per slot |
| ren_psrc2 | output | 4x6 | Physical register of second source per slot |
| ren_pold | output | 4x6 | Previous mapping of the destination per slot |
| ret_valid | input | 4 | Per-lane release of a physical register |
| ret_preg | input | 4x6 | Physical register released on each lane |

## Verification
The hardest state to reach from the ports is a near-empty pool, where a group must stall while a group without writers still passes and a single release alone decides which register the next writer gets. The stimulus renames full groups with releases withheld until the model's pool runs dry, checks the stall, then releases one known register and renames a lone writer. Random groups draw destinations from a narrow range so that repeated writes and same-group reads of one register are frequent.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned ARCH_REGS_DEF = 32;
    localparam int unsigned PHYS_REGS_DEF = 64;
    localparam int unsigned GROUP_DEF     = 4;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
    parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
    parameter int unsigned WIDTH    = rn_pkg::GROUP_DEF,
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned CW      = $clog2(WIDTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take,
    input  logic [CW-1:0]             take_cnt,
    input  logic [WIDTH-1:0]          rel_valid,
    input  logic [WIDTH-1:0][PW-1:0]  rel_idx,
    output logic [WIDTH-1:0]          grant_ok,
    output logic [WIDTH-1:0][PW-1:0]  grant_idx,
    output logic [NUM_PHYS-1:0]       free_vec
);
    typedef struct packed {
        logic [NUM_PHYS-1:0] avail;
    } fl_state_t;

    fl_state_t st_d, st_q;
    logic [WIDTH:0][NUM_PHYS-1:0] scan;

    assign scan[0]  = st_q.avail;
    assign free_vec = st_q.avail;

    for (genvar k = 0; k < WIDTH; k++) begin : g_pick
        always_comb begin
            grant_ok[k]  = |scan[k];
            grant_idx[k] = '0;
            for (int p = NUM_PHYS - 1; p >= 0; p--) begin
                if (scan[k][p]) grant_idx[k] = PW'(p);
            end
            scan[k+1] = scan[k];
            if (grant_ok[k]) scan[k+1][grant_idx[k]] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < WIDTH; k++) begin
            if (take && (k < int'(take_cnt))) st_d.avail[grant_idx[k]] = 1'b0;
        end
        for (int k = 0; k < WIDTH; k++) begin
            if (rel_valid[k]) st_d.avail[rel_idx[k]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PHYS; p++) st_q.avail[p] <= (p >= NUM_ARCH);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
    parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
    parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
    parameter int unsigned WIDTH    = rn_pkg::GROUP_DEF,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [WIDTH-1:0]          wr_en,
    input  logic [WIDTH-1:0][AW-1:0]  wr_dst,
    input  logic [WIDTH-1:0][PW-1:0]  wr_pdst,
    input  logic [WIDTH-1:0][AW-1:0]  rd_a,
    input  logic [WIDTH-1:0][AW-1:0]  rd_b,
    output logic [WIDTH-1:0][PW-1:0]  ph_a,
    output logic [WIDTH-1:0][PW-1:0]  ph_b,
    output logic [WIDTH-1:0][PW-1:0]  ph_old
);
    typedef struct packed {
        logic [NUM_ARCH-1:0][PW-1:0] map;
    } mt_state_t;

    mt_state_t st_d, st_q;

    // Lookups see the table plus every earlier writer of the group.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            ph_a[i]   = st_q.map[rd_a[i]];
            ph_b[i]   = st_q.map[rd_b[i]];
            ph_old[i] = st_q.map[wr_dst[i]];
            for (int j = 0; j < WIDTH; j++) begin
                if (j < i && wr_en[j]) begin
                    if (wr_dst[j] == rd_a[i])   ph_a[i]   = wr_pdst[j];
                    if (wr_dst[j] == rd_b[i])   ph_b[i]   = wr_pdst[j];
                    if (wr_dst[j] == wr_dst[i]) ph_old[i] = wr_pdst[j];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            if (commit && wr_en[i]) st_d.map[wr_dst[i]] = wr_pdst[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ARCH; r++) st_q.map[r] <= PW'(r);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
    parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
    parameter int unsigned WIDTH    = rn_pkg::GROUP_DEF,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grp_valid,
    input  logic [WIDTH-1:0]          grp_wen,
    input  logic [WIDTH-1:0][AW-1:0]  grp_dst,
    input  logic [WIDTH-1:0][AW-1:0]  grp_src1,
    input  logic [WIDTH-1:0][AW-1:0]  grp_src2,
    output logic                      grp_ok,
    output logic [WIDTH-1:0][PW-1:0]  ren_pdst,
    output logic [WIDTH-1:0][PW-1:0]  ren_psrc1,
    output logic [WIDTH-1:0][PW-1:0]  ren_psrc2,
    output logic [WIDTH-1:0][PW-1:0]  ren_pold,
    input  logic [WIDTH-1:0]          ret_valid,
    input  logic [WIDTH-1:0][PW-1:0]  ret_preg
);
    localparam int unsigned CW = $clog2(WIDTH + 1);

    logic [WIDTH-1:0]          wr_eff;
    logic [WIDTH-1:0][CW-1:0]  slot_ord;
    logic [CW-1:0]             need;
    logic [WIDTH-1:0]          grant_ok;
    logic [WIDTH-1:0][PW-1:0]  grant_idx;
    logic [NUM_PHYS-1:0]       free_vec;
    logic                      fire;

    // Writers to register 0 are not renamed; each real writer takes the
    // grant whose rank equals the count of real writers before it.
    always_comb begin
        need = '0;
        for (int i = 0; i < WIDTH; i++) begin
            wr_eff[i]   = grp_wen[i] && (grp_dst[i] != '0);
            slot_ord[i] = need;
            if (wr_eff[i]) need = need + CW'(1);
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            ren_pdst[i] = '0;
            for (int k = 0; k < WIDTH; k++) begin
                if (wr_eff[i] && (int'(slot_ord[i]) == k)) ren_pdst[i] = grant_idx[k];
            end
        end
    end

    always_comb begin
        fire = grp_valid && (need == '0);
        for (int k = 0; k < WIDTH; k++) begin
            if (grp_valid && (int'(need) == k + 1)) fire = grant_ok[k];
        end
    end

    assign grp_ok = fire;

    rn_freelist #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .WIDTH    (WIDTH)
    ) u_fl (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (fire),
        .take_cnt  (need),
        .rel_valid (ret_valid),
        .rel_idx   (ret_preg),
        .grant_ok  (grant_ok),
        .grant_idx (grant_idx),
        .free_vec  (free_vec)
    );

    rn_maptable #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .WIDTH    (WIDTH)
    ) u_mt (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (fire),
        .wr_en   (wr_eff),
        .wr_dst  (grp_dst),
        .wr_pdst (ren_pdst),
        .rd_a    (grp_src1),
        .rd_b    (grp_src2),
        .ph_a    (ren_psrc1),
        .ph_b    (ren_psrc2),
        .ph_old  (ren_pold)
    );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int unsigned NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
    parameter int unsigned NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
    parameter int unsigned WIDTH    = rn_pkg::GROUP_DEF,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      grp_valid,
    input logic [WIDTH-1:0]          grp_wen,
    input logic [WIDTH-1:0][AW-1:0]  grp_dst,
    input logic [WIDTH-1:0][AW-1:0]  grp_src1,
    input logic [WIDTH-1:0][PW-1:0]  ren_pdst,
    input logic [WIDTH-1:0][PW-1:0]  ren_psrc1,
    input logic [WIDTH-1:0][PW-1:0]  ren_pold,
    input logic                      grp_ok,
    input logic [WIDTH-1:0]          ret_valid,
    input logic [NUM_PHYS-1:0]       free_vec
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        // R2
        alloc_from_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_ok && grp_wen[i] && grp_dst[i] != '0) |-> free_vec[ren_pdst[i]]);
        // R2
        alloc_leaves_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_ok && grp_wen[i] && grp_dst[i] != '0) |=> !free_vec[$past(ren_pdst[i])]);
        // R8
        zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_src1[i] == '0) |-> (ren_psrc1[i] == '0));
        // R8
        zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_wen[i] && grp_dst[i] == '0) |-> (ren_pdst[i] == '0 && ren_pold[i] == '0));
        for (genvar j = i + 1; j < WIDTH; j++) begin : g_pair
            // R2
            distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_ok && grp_wen[i] && grp_wen[j] && grp_dst[i] != '0 && grp_dst[j] != '0)
                |-> (ren_pdst[i] != ren_pdst[j]));
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_ok && ret_valid == '0) |=> $stable(free_vec));
endmodule

bind rn_rename rn_rename_chk #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS),
    .WIDTH    (WIDTH)
) u_chk (.*);

// File: tb/rn_rename_tb.sv
module rn_rename_tb;
    localparam int W  = 4;
    localparam int NA = 32;
    localparam int NP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid = 1'b0;
    logic [W-1:0] grp_wen = '0;
    logic [W-1:0][4:0] grp_dst = '0, grp_src1 = '0, grp_src2 = '0;
    logic grp_ok;
    logic [W-1:0][5:0] ren_pdst, ren_psrc1, ren_psrc2, ren_pold;
    logic [W-1:0] ret_valid = '0;
    logic [W-1:0][5:0] ret_preg = '0;

    always #2 clk = ~clk;

    rn_rename u_dut (.*);

    int checks = 0;
    int fails = 0;
    logic [5:0] m_map [NA];
    bit         m_free [NP];
    logic [5:0] q [64];
    int q_rd = 0, q_cnt = 0;
    logic [5:0] last_rel;

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int free_cnt();
        int c = 0;
        for (int p = 0; p < NP; p++) c += int'(m_free[p]);
        return c;
    endfunction

    // Called right after a negedge with group inputs already set.
    task automatic step(input int nrel);
        logic [5:0] tm [NA];
        bit tf [NP];
        bit written [NA];
        bit wr [W];
        int need = 0;
        bit ok;
        ret_valid = '0;
        for (int k = 0; k < W; k++) begin
            if (k < nrel && q_cnt > 0) begin
                ret_valid[k] = 1'b1;
                ret_preg[k]  = q[q_rd];
                last_rel     = q[q_rd];
                q_rd = (q_rd + 1) % 64;
                q_cnt--;
            end
        end
        #1;
        for (int i = 0; i < W; i++) begin
            wr[i] = grp_wen[i] && grp_dst[i] != 0;
            need += int'(wr[i]);
        end
        ok = grp_valid && (need <= free_cnt());
        chk(grp_ok == ok, "R7 accept", int'(grp_ok), int'(ok));
        if (ok && grp_ok) begin
            for (int r = 0; r < NA; r++) begin tm[r] = m_map[r]; written[r] = 0; end
            for (int p = 0; p < NP; p++) tf[p] = m_free[p];
            for (int i = 0; i < W; i++) begin
                logic [5:0] e;
                e = tm[grp_src1[i]];
                chk(ren_psrc1[i] == e, grp_src1[i] == 0 ? "R8 src1" :
                    (written[grp_src1[i]] ? "R4 src1 bypass" : "R3 src1"),
                    int'(ren_psrc1[i]), int'(e));
                e = tm[grp_src2[i]];
                chk(ren_psrc2[i] == e, grp_src2[i] == 0 ? "R8 src2" :
                    (written[grp_src2[i]] ? "R4 src2 bypass" : "R3 src2"),
                    int'(ren_psrc2[i]), int'(e));
                if (wr[i]) begin
                    logic [5:0] pd = 0;
                    for (int p = NP - 1; p >= 0; p--) if (tf[p]) pd = 6'(p);
                    chk(ren_pdst[i] == pd, "R2/R10 pdst", int'(ren_pdst[i]), int'(pd));
                    chk(ren_pold[i] == tm[grp_dst[i]],
                        written[grp_dst[i]] ? "R5 pold repeat" : "R6 pold",
                        int'(ren_pold[i]), int'(tm[grp_dst[i]]));
                    tf[pd] = 0;
                    q[(q_rd + q_cnt) % 64] = tm[grp_dst[i]];
                    q_cnt++;
                    tm[grp_dst[i]] = pd;
                    written[grp_dst[i]] = 1;
                end else if (grp_wen[i]) begin
                    chk(ren_pdst[i] == 0 && ren_pold[i] == 0, "R8 dst zero",
                        int'(ren_pdst[i]), 0);
                end
            end
            for (int r = 0; r < NA; r++) m_map[r] = tm[r];
            for (int p = 0; p < NP; p++) m_free[p] = tf[p];
        end
        for (int k = 0; k < W; k++) if (ret_valid[k]) m_free[ret_preg[k]] = 1;
        @(negedge clk);
    endtask

    task automatic rand_group(input int narrow);
        grp_valid = 1'b1;
        for (int i = 0; i < W; i++) begin
            grp_wen[i]  = ($urandom_range(0, 3) != 0);
            grp_dst[i]  = narrow != 0 ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            grp_src1[i] = narrow != 0 ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            grp_src2[i] = 5'($urandom_range(0, 31));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < NA; r++) m_map[r] = 6'(r);
        for (int p = 0; p < NP; p++) m_free[p] = (p >= NA);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: identity mapping right after reset
        grp_valid = 1'b1;
        grp_wen = '0;
        for (int i = 0; i < W; i++) begin
            grp_src1[i] = 5'(i * 9 + 1);
            grp_src2[i] = 5'(31 - i);
        end
        #1;
        for (int i = 0; i < W; i++) begin
            chk(ren_psrc1[i] == 6'(i * 9 + 1), "R1 reset map", int'(ren_psrc1[i]), i * 9 + 1);
            chk(ren_psrc2[i] == 6'(31 - i), "R1 reset map", int'(ren_psrc2[i]), 31 - i);
        end
        @(negedge clk);
        // R1/R10: first writer gets register 32
        grp_wen = 4'b0001; grp_dst[0] = 5'd7;
        #1;
        chk(ren_pdst[0] == 6'd32, "R1 first free", int'(ren_pdst[0]), 32);
        chk(ren_pold[0] == 6'd7, "R1 old identity", int'(ren_pold[0]), 7);
        step(0);

        // R5/R4 directed: same destination three times in one group
        grp_wen = 4'b1111;
        grp_dst = {5'd5, 5'd5, 5'd0, 5'd5};
        grp_src1 = {5'd5, 5'd5, 5'd5, 5'd5};
        step(0);

        // random traffic with frequent collisions
        for (int n = 0; n < 600; n++) begin
            rand_group(int'($urandom_range(0, 1)));
            grp_valid = ($urandom_range(0, 7) != 0);
            step(int'($urandom_range(0, W)));
        end

        // R7: drain pool with no releases until a full group stalls
        grp_valid = 1'b1;
        for (int n = 0; n < 40; n++) begin
            grp_wen = 4'b1111;
            grp_dst = {5'd1, 5'd2, 5'd3, 5'd4};
            step(0);
        end
        chk(free_cnt() < W, "R7 pool drained", free_cnt(), 0);
        // a writer-free group still passes with an empty pool
        grp_wen = '0;
        step(0);
        // empty the last few free registers with lone writers
        for (int n = 0; n < W; n++) begin
            grp_wen = 4'b0001; grp_dst[0] = 5'd9;
            step(0);
        end
        chk(free_cnt() == 0, "R7 pool empty", free_cnt(), 0);
        // R9: release one register, lone writer must receive it next cycle
        grp_valid = 1'b0;
        step(1);
        grp_valid = 1'b1;
        grp_wen = 4'b0001; grp_dst[0] = 5'd11;
        #1;
        chk(grp_ok == 1'b1, "R9 released accepted", int'(grp_ok), 1);
        chk(ren_pdst[0] == last_rel, "R9 released reused", int'(ren_pdst[0]), int'(last_rel));
        step(0);
        // recover pool and run more random traffic
        for (int n = 0; n < 200; n++) begin
            rand_group(1);
            step(W);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule